// File: doc/BRIEF.md
# Three-Byte Indirect Register Access Sequencer

This block gives a host a single byte-wide window into internal registers and control memories. The host moves an access as three consecutive byte transfers on one port address: first a control byte, then a data byte, then an address byte. The control byte selects the target class, whether the internal operation reads or writes, a two-bit attribute, and two extra data bits that widen the data byte to ten bits. A busy flag rises with the first byte. Once the third byte lands the block issues one internal request and holds busy for a fixed, parameterised number of cycles, after which busy falls.

A read needs two phases. A three-byte request sequence names the target, and its data byte is ignored. Once busy falls, three host reads from the same port return the control byte (with its two wide-data bits replaced by the bits read), the low data byte and the address byte. The first result read raises busy again, and after the third one busy stays high for a fixed drain time. One target class only yields a result after two identical request sequences. A mode register can abort the sequence at any point. Direct registers (status, mode, scratch) stay reachable between the byte transfers without disturbing the sequence. Illegal port accesses are dropped and latch a sticky error bit.

Top module: `ind_access_seq`

## Requirements
- R1: After reset, the busy output is 0, host read data is 0x00, the internal request is 0, and the status register reads 0x00.
- R2: Control byte bit positions: bit7 = wide data bit 8, bits6:5 = target class, bits4:3 = attribute, bit2 = read request (1) or write (0), bit1 = sub-select, bit0 = wide data bit 9. The internal request carries mem_sel = {bits6:5, bit2, bit1}, mem_attr = bits4:3, mem_addr = address byte, mem_wdata = {bit0, bit7, data byte}, and mem_we = inverse of bit2.
- R3: Busy rises on the clock edge that accepts the first byte of a sequence, and after the edge that accepts the third byte it stays high for exactly ACC_CYC cycles before it falls.
- R4: Each completed three-byte sequence produces exactly one single-cycle mem_req, in the cycle after the third byte, while busy is high, and mem_addr stays stable for the whole internal access.
- R5: After a read request completes, three port reads return {rd[8], control bits6:1, rd[9]}, rd[7:0] and the address byte, in that order, where rd is the 10-bit mem_rdata. The first of these reads raises busy, and after the third one busy stays high for exactly RST_CYC cycles.
- R6: A read request to target class 2'b11 yields a result only when it is the second identical sequence in a row. After the first sequence busy falls and a port read returns 0x00 without raising busy.
- R7: While the external-busy input is 1, a port write in the idle state starts nothing (busy stays 0) and sets the error bit. Status bit1 shows the external-busy input.
- R8: Port writes or reads during the internal access or the drain time, and port writes during the result phase, are ignored and set the sticky error bit (status bit2). The bit stays set until a mode-register write with bit1 = 1.
- R9: A mode-register write with bit0 = 1 returns the sequencer to idle on that edge, drops a partly written sequence and discards a pending result.
- R10: Host register map: address 0 = status (bit0 busy, bit1 external busy, bit2 error), 1 = mode (write-only, reads 0x00), 2 = indirect port, 3 = scratch byte. Read data appears on host_rdata the cycle after the read strobe. Direct accesses between sequence bytes leave the sequence intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe, one cycle per transfer |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| ext_busy | input | 1 | External hold-off; blocks new sequences |
| ind_busy | output | 1 | Indirect sequence busy flag |
| mem_req | output | 1 | Single-cycle internal access request |
| mem_we | output | 1 | Internal access is a write |
| mem_sel | output | 4 | Target class, read flag and sub-select |
| mem_attr | output | 2 | Attribute field |
| mem_addr | output | 8 | Internal location address |
| mem_wdata | output | 10 | Internal write data |
| mem_rdata | input | 10 | Internal read data, valid by the end of the access time |

## Verification
The embedded assertions check on every cycle that mem_req is a one-cycle pulse that only occurs while busy is high, that mem_addr holds during the internal access, that the timer keeps running until it has counted down, that an abort leaves busy low, that a refused start keeps busy low, and that the error bit stays set until it is cleared. The exact busy windows of ACC_CYC and RST_CYC cycles, the byte order and bit placement of returned results, and the two-pass rule for class 2'b11 can only be shown by the bench's scenarios. The same holds for the ignored accesses that leave the sequence intact and the aborts at each phase.

// File: rtl/iax_pkg.sv
package iax_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_COLLECT,
    S_ACCESS,
    S_RESULT,
    S_RDOUT,
    S_DRAIN
  } seq_state_t;

  // Control byte, most significant field first (bit 7 down to bit 0)
  typedef struct packed {
    logic       d8;
    logic [1:0] tgt;
    logic [1:0] attr;
    logic       rd;
    logic       sub;
    logic       d9;
  } ctrl_t;

  localparam logic [1:0] HA_STATUS  = 2'd0;
  localparam logic [1:0] HA_MODE    = 2'd1;
  localparam logic [1:0] HA_PORT    = 2'd2;
  localparam logic [1:0] HA_SCRATCH = 2'd3;

  localparam logic [1:0] TGT_TWO_PASS = 2'b11;

endpackage

// File: rtl/iax_timer.sv
module iax_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= load_val;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expire = active && (cnt == '0);

  // R3: a running countdown cannot stop before reaching zero
  a_r3_timer_hold: assert property (@(posedge clk) disable iff (rst)
    (active && cnt != '0 && !clr && !load) |=> active);

endmodule

// File: rtl/iax_dregs.sv
module iax_dregs (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_cs,
  input  logic       host_we,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       stat_busy,
  input  logic       stat_ext,
  input  logic       stat_err,
  input  logic [7:0] port_byte,
  output logic       abort_p,
  output logic       err_clr_p,
  output logic [7:0] host_rdata
);
  import iax_pkg::*;

  logic [7:0] scratch_q;
  logic       mode_wr;
  logic       rd_stb;

  assign mode_wr   = host_cs && host_we && (host_addr == HA_MODE);
  assign rd_stb    = host_cs && !host_we;
  assign abort_p   = mode_wr && host_wdata[0];
  assign err_clr_p = mode_wr && host_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q  <= '0;
      host_rdata <= '0;
    end else begin
      if (host_cs && host_we && host_addr == HA_SCRATCH)
        scratch_q <= host_wdata;
      if (rd_stb) begin
        unique case (host_addr)
          HA_STATUS:  host_rdata <= {5'b0, stat_err, stat_ext, stat_busy};
          HA_MODE:    host_rdata <= 8'h00;
          HA_PORT:    host_rdata <= port_byte;
          default:    host_rdata <= scratch_q;
        endcase
      end
    end
  end

  // R10: mode register is write-only and always reads back as zero
  a_r10_mode_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (host_cs && !host_we && host_addr == HA_MODE) |=> (host_rdata == 8'h00));

endmodule

// File: rtl/iax_seq.sv
module iax_seq #(
  parameter int ACC_CYC = 90,
  parameter int RST_CYC = 90,
  parameter int CNT_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_wr,
  input  logic             port_rd,
  input  logic [7:0]       wdata,
  input  logic             abort_p,
  input  logic             err_clr_p,
  input  logic             ext_busy,
  input  logic             timer_expire,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic [7:0]       port_byte,
  output logic             busy,
  output logic             err,
  output logic             mem_req,
  output logic             mem_we,
  output logic [3:0]       mem_sel,
  output logic [1:0]       mem_attr,
  output logic [7:0]       mem_addr,
  output logic [9:0]       mem_wdata,
  input  logic [9:0]       mem_rdata
);
  import iax_pkg::*;

  seq_state_t state, state_n;
  logic [1:0] idx, idx_n;
  ctrl_t      ctrl_q, pass_ctrl;
  logic [7:0] data_q, addr_q, pass_addr;
  logic [9:0] res_q;
  logic       pass_valid, pass_match;
  logic       cap_ctrl, cap_data, cap_addr, take_res, arm_pass, drop_pass, err_set;

  assign pass_match = pass_valid && (pass_ctrl == ctrl_q) && (pass_addr == addr_q);

  always_comb begin
    state_n    = state;
    idx_n      = idx;
    timer_load = 1'b0;
    timer_val  = '0;
    cap_ctrl   = 1'b0;
    cap_data   = 1'b0;
    cap_addr   = 1'b0;
    take_res   = 1'b0;
    arm_pass   = 1'b0;
    drop_pass  = 1'b0;
    err_set    = 1'b0;
    if (abort_p) begin
      state_n   = S_IDLE;
      idx_n     = 2'd0;
      drop_pass = 1'b1;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (port_wr) begin
            if (ext_busy) err_set = 1'b1;
            else begin
              cap_ctrl = 1'b1;
              state_n  = S_COLLECT;
              idx_n    = 2'd1;
            end
          end
        end
        S_COLLECT: begin
          if (port_wr) begin
            if (idx == 2'd1) begin
              cap_data = 1'b1;
              idx_n    = 2'd2;
            end else begin
              cap_addr   = 1'b1;
              state_n    = S_ACCESS;
              idx_n      = 2'd0;
              timer_load = 1'b1;
              timer_val  = CNT_W'(ACC_CYC - 1);
            end
          end
        end
        S_ACCESS: begin
          if (port_wr || port_rd) err_set = 1'b1;
          if (timer_expire) begin
            if (!ctrl_q.rd) begin
              state_n   = S_IDLE;
              drop_pass = 1'b1;
            end else if (ctrl_q.tgt == TGT_TWO_PASS && !pass_match) begin
              state_n  = S_IDLE;
              arm_pass = 1'b1;
            end else begin
              state_n   = S_RESULT;
              take_res  = 1'b1;
              drop_pass = 1'b1;
            end
          end
        end
        S_RESULT: begin
          if (port_wr) err_set = 1'b1;
          else if (port_rd) begin
            state_n = S_RDOUT;
            idx_n   = 2'd1;
          end
        end
        S_RDOUT: begin
          if (port_wr) err_set = 1'b1;
          else if (port_rd) begin
            if (idx == 2'd2) begin
              state_n    = S_DRAIN;
              idx_n      = 2'd0;
              timer_load = 1'b1;
              timer_val  = CNT_W'(RST_CYC - 1);
            end else begin
              idx_n = idx + 2'd1;
            end
          end
        end
        default: begin
          if (port_wr || port_rd) err_set = 1'b1;
          if (timer_expire) state_n = S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx        <= 2'd0;
      ctrl_q     <= '0;
      data_q     <= '0;
      addr_q     <= '0;
      res_q      <= '0;
      pass_valid <= 1'b0;
      pass_ctrl  <= '0;
      pass_addr  <= '0;
      err        <= 1'b0;
      mem_req    <= 1'b0;
    end else begin
      state   <= state_n;
      idx     <= idx_n;
      mem_req <= cap_addr;
      if (cap_ctrl) ctrl_q <= ctrl_t'(wdata);
      if (cap_data) data_q <= wdata;
      if (cap_addr) addr_q <= wdata;
      if (take_res) res_q  <= mem_rdata;
      if (arm_pass) begin
        pass_valid <= 1'b1;
        pass_ctrl  <= ctrl_q;
        pass_addr  <= addr_q;
      end else if (drop_pass) begin
        pass_valid <= 1'b0;
      end
      if (err_clr_p)    err <= 1'b0;
      else if (err_set) err <= 1'b1;
    end
  end

  always_comb begin
    port_byte = 8'h00;
    if (state == S_RESULT || state == S_RDOUT) begin
      unique case (idx)
        2'd0:    port_byte = {res_q[8], ctrl_q.tgt, ctrl_q.attr, ctrl_q.rd, ctrl_q.sub, res_q[9]};
        2'd1:    port_byte = res_q[7:0];
        default: port_byte = addr_q;
      endcase
    end
  end

  assign busy      = (state == S_COLLECT) || (state == S_ACCESS) ||
                     (state == S_RDOUT)   || (state == S_DRAIN);
  assign mem_we    = !ctrl_q.rd;
  assign mem_sel   = {ctrl_q.tgt, ctrl_q.rd, ctrl_q.sub};
  assign mem_attr  = ctrl_q.attr;
  assign mem_addr  = addr_q;
  assign mem_wdata = {ctrl_q.d9, ctrl_q.d8, data_q};

  // R4: the internal request lasts exactly one cycle
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R3: a request is only issued while the busy flag is up
  a_r3_req_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R4: the location address holds for the whole internal access
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (state == S_ACCESS && $past(state == S_ACCESS)) |-> $stable(mem_addr));

  // R9: an abort leaves the sequencer not busy
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
    abort_p |=> !busy);

  // R7: a refused start keeps busy low
  a_r7_refused_start: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && ext_busy && port_wr && !abort_p) |=> !busy);

  // R8: the error bit stays set until explicitly cleared
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr_p) |=> err);

endmodule

// File: rtl/ind_access_seq.sv
module ind_access_seq #(
  parameter int ACC_CYC = 90,
  parameter int RST_CYC = 90
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_cs,
  input  logic       host_we,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       ext_busy,
  output logic       ind_busy,
  output logic       mem_req,
  output logic       mem_we,
  output logic [3:0] mem_sel,
  output logic [1:0] mem_attr,
  output logic [7:0] mem_addr,
  output logic [9:0] mem_wdata,
  input  logic [9:0] mem_rdata
);
  import iax_pkg::*;

  localparam int MAX_CYC = (ACC_CYC > RST_CYC) ? ACC_CYC : RST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             port_wr, port_rd;
  logic             abort_p, err_clr_p, err;
  logic             t_load, t_expire;
  logic [CNT_W-1:0] t_val;
  logic [7:0]       port_byte;

  assign port_wr = host_cs &&  host_we && (host_addr == HA_PORT);
  assign port_rd = host_cs && !host_we && (host_addr == HA_PORT);

  iax_dregs u_dregs (
    .clk        (clk),
    .rst        (rst),
    .host_cs    (host_cs),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .stat_busy  (ind_busy),
    .stat_ext   (ext_busy),
    .stat_err   (err),
    .port_byte  (port_byte),
    .abort_p    (abort_p),
    .err_clr_p  (err_clr_p),
    .host_rdata (host_rdata)
  );

  iax_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (abort_p),
    .load     (t_load),
    .load_val (t_val),
    .expire   (t_expire)
  );

  iax_seq #(
    .ACC_CYC (ACC_CYC),
    .RST_CYC (RST_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .port_wr      (port_wr),
    .port_rd      (port_rd),
    .wdata        (host_wdata),
    .abort_p      (abort_p),
    .err_clr_p    (err_clr_p),
    .ext_busy     (ext_busy),
    .timer_expire (t_expire),
    .timer_load   (t_load),
    .timer_val    (t_val),
    .port_byte    (port_byte),
    .busy         (ind_busy),
    .err          (err),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_sel      (mem_sel),
    .mem_attr     (mem_attr),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata)
  );

endmodule

// File: tb/ind_access_seq_bench.sv
module ind_access_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACC        = 90;
  localparam int RST        = 90;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_cs = 1'b0, host_we = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       ext_busy = 1'b0;
  logic       ind_busy, mem_req, mem_we;
  logic [3:0] mem_sel;
  logic [1:0] mem_attr;
  logic [7:0] mem_addr;
  logic [9:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_access_seq #(.ACC_CYC(ACC), .RST_CYC(RST)) u_ind_access_seq (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ext_busy(ext_busy), .ind_busy(ind_busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_sel(mem_sel), .mem_attr(mem_attr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model: a computed read-only pattern per address
  function automatic logic [9:0] mem_model(input logic [7:0] a);
    return {a[1:0], a ^ 8'hA5};
  endfunction
  assign mem_rdata = mem_model(mem_addr);

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard for host read data
  typedef struct { logic [7:0] v; string req; } exp_t;
  exp_t sb_q[$];
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= host_cs && !host_we;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL scoreboard: read data 0x%0h with no expected item", host_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, {24'b0, host_rdata}, {24'b0, e.v});
      end
    end
  end

  // Request monitor
  int         req_cnt = 0;
  logic       l_we;
  logic [3:0] l_sel;
  logic [1:0] l_attr;
  logic [7:0] l_addr;
  logic [9:0] l_wdata;

  always @(posedge clk) begin
    if (!rst && mem_req) begin
      req_cnt = req_cnt + 1;
      l_we = mem_we; l_sel = mem_sel; l_attr = mem_attr;
      l_addr = mem_addr; l_wdata = mem_wdata;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > WATCHDOG) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic bus(input logic [1:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus(a, 1'b1, d);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    exp_t e;
    e.v = exp; e.req = req;
    sb_q.push_back(e);
    bus(a, 1'b0, 8'h00);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (ind_busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic seq3(input logic [7:0] c, input logic [7:0] d, input logic [7:0] a);
    wr(2'd2, c); wr(2'd2, d); wr(2'd2, a);
  endtask

  initial begin
    int n;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", {31'b0, ind_busy}, 0);
    chk("R1 rdata", {24'b0, host_rdata}, 0);
    chk("R1 mem_req", {31'b0, mem_req}, 0);
    rd(2'd0, 8'h00, "R1 status");

    // R2/R3/R4: write sequence, ctrl 0xB1 data 0x3C addr 0x47
    base = req_cnt;
    wr(2'd2, 8'hB1);
    chk("R3 busy after first byte", {31'b0, ind_busy}, 1);
    wr(2'd2, 8'h3C);
    wr(2'd2, 8'h47);
    count_busy(n);
    chk("R3 busy window after third byte", n, ACC);
    chk("R4 one request", req_cnt - base, 1);
    chk("R2 mem_we", {31'b0, l_we}, 1);
    chk("R2 mem_sel", {28'b0, l_sel}, 4'b0100);
    chk("R2 mem_attr", {30'b0, l_attr}, 2'b10);
    chk("R2 mem_addr", {24'b0, l_addr}, 8'h47);
    chk("R2 mem_wdata", {22'b0, l_wdata}, 10'h33C);

    // R10: direct registers between sequence bytes
    base = req_cnt;
    wr(2'd2, 8'h08);
    wr(2'd3, 8'h9E);
    rd(2'd3, 8'h9E, "R10 scratch between bytes");
    wr(2'd2, 8'hC3);
    rd(2'd0, 8'h01, "R10 status busy mid sequence");
    rd(2'd1, 8'h00, "R10 mode reads zero");
    wr(2'd2, 8'h5D);
    count_busy(n);
    chk("R10 sequence intact count", n, ACC);
    chk("R10 request issued", req_cnt - base, 1);
    chk("R10 addr intact", {24'b0, l_addr}, 8'h5D);
    chk("R10 wdata intact", {22'b0, l_wdata}, 10'h0C3);
    chk("R10 attr intact", {30'b0, l_attr}, 2'b01);

    // R5: read sequence ctrl 0x4C addr 0x6B, rd = 0x3CE
    seq3(8'h4C, 8'hFF, 8'h6B);
    count_busy(n);
    chk("R5 access window", n, ACC);
    chk("R5 mem_we read", {31'b0, l_we}, 0);
    chk("R5 mem_sel", {28'b0, l_sel}, 4'b1010);
    rd(2'd2, 8'hCD, "R5 result control byte");
    chk("R5 busy after first read", {31'b0, ind_busy}, 1);
    rd(2'd2, 8'hCE, "R5 result data byte");
    rd(2'd2, 8'h6B, "R5 result address byte");
    count_busy(n);
    chk("R5 drain window", n, RST);

    // R6: two-pass class, ctrl 0x64 addr 0x12, rd = 0x2B7
    seq3(8'h64, 8'h00, 8'h12);
    count_busy(n);
    chk("R6 first pass window", n, ACC);
    rd(2'd2, 8'h00, "R6 no result after first pass");
    chk("R6 busy stays low", {31'b0, ind_busy}, 0);
    seq3(8'h64, 8'h00, 8'h12);
    count_busy(n);
    rd(2'd2, 8'h65, "R6 result control byte");
    rd(2'd2, 8'hB7, "R6 result data byte");
    rd(2'd2, 8'h12, "R6 result address byte");
    count_busy(n);
    chk("R6 drain window", n, RST);

    // R7: external busy refuses a start
    ext_busy = 1'b1;
    wr(2'd2, 8'h00);
    chk("R7 busy stays low", {31'b0, ind_busy}, 0);
    rd(2'd0, 8'h06, "R7 status ext and error");
    ext_busy = 1'b0;
    wr(2'd1, 8'h02);
    rd(2'd0, 8'h00, "R8 error cleared");

    // R8: port access during internal access
    base = req_cnt;
    seq3(8'h00, 8'h11, 8'h22);
    wr(2'd2, 8'h55);
    count_busy(n);
    chk("R8 single request", req_cnt - base, 1);
    chk("R8 addr kept", {24'b0, l_addr}, 8'h22);
    rd(2'd0, 8'h04, "R8 error after access-phase write");
    rd(2'd0, 8'h04, "R8 error sticky");
    wr(2'd1, 8'h02);

    // R8: write during result phase, ctrl 0x04 addr 0x30, rd = 0x095
    seq3(8'h04, 8'h00, 8'h30);
    count_busy(n);
    wr(2'd2, 8'h77);
    chk("R8 result-phase write starts nothing", {31'b0, ind_busy}, 0);
    rd(2'd0, 8'h04, "R8 error after result-phase write");
    rd(2'd2, 8'h04, "R8 result control intact");
    rd(2'd2, 8'h95, "R8 result data intact");
    rd(2'd2, 8'h30, "R8 result address intact");
    count_busy(n);
    wr(2'd1, 8'h02);
    rd(2'd0, 8'h00, "R8 error cleared again");

    // R9: abort of a partial sequence
    wr(2'd2, 8'h4C);
    wr(2'd2, 8'hAA);
    wr(2'd1, 8'h01);
    chk("R9 busy low after abort", {31'b0, ind_busy}, 0);
    base = req_cnt;
    seq3(8'h08, 8'h5A, 8'h01);
    count_busy(n);
    chk("R9 fresh sequence window", n, ACC);
    chk("R9 fresh request", req_cnt - base, 1);
    chk("R9 fresh addr", {24'b0, l_addr}, 8'h01);
    chk("R9 fresh sel", {28'b0, l_sel}, 4'b0000);
    chk("R9 fresh wdata", {22'b0, l_wdata}, 10'h05A);

    // R9: abort discards a pending result
    seq3(8'h04, 8'h00, 8'h30);
    count_busy(n);
    wr(2'd1, 8'h01);
    rd(2'd2, 8'h00, "R9 result discarded");
    chk("R9 busy low after discard", {31'b0, ind_busy}, 0);

    // R9: abort during internal access
    seq3(8'h00, 8'h01, 8'h02);
    wr(2'd1, 8'h01);
    chk("R9 busy low after access abort", {31'b0, ind_busy}, 0);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule